// File: doc/BRIEF.md
# Serial Bus Wake and Loopback Controller

This block sits between a serial bus link-layer core and the transceiver pins. It provides three things. The first is a low-power stop state, in which the link clock enable is withdrawn and the block watches the receive pin. The second is a digital loopback, in which link transmit data returns to the link receive input without reaching the pins. The third is an analog loopback, which leaves the digital paths alone. After a wake or the end of either loopback, the block keeps the link from transmitting until it sees the bus quiet for a programmed number of cycles. The bus is passive at logic 0 and active at logic 1.

The controller is a five-state machine. RUN is normal operation. STOPPED has the clock enable off and waits for a wake edge. STARTUP is a delay for oscillator restart. WAKE_WAIT is an idle wait that discards the waking frame. LB_WAIT is an idle wait after a loopback ends. The transitions are:
- RUN→STOPPED on an accepted stop.
- RUN→LB_WAIT when the last active loopback drops.
- STOPPED→STARTUP on a rising edge of the synchronised receive pin.
- STARTUP→WAKE_WAIT when the restart counter expires.
- WAKE_WAIT→RUN and LB_WAIT→RUN once the idle detector declares the bus idle.

Top module: `bus_wake_lpbk`

## Requirements
- R1: When `wcm_arm`=1, `stop_req`=1 and `tx_active`=0 are sampled together in RUN, `link_clk_en` goes to 0 after that clock edge, and `tx_hold` and `rx_discard` go to 1.
- R2: `wcm_arm` alone, or `stop_req` with `wcm_arm`=0, leaves `link_clk_en`=1 and `tx_hold`=0.
- R3: A stop request with `wcm_arm`=1 while `tx_active`=1 is refused, so `link_clk_en` stays 1. `stop_refused` goes to 1 after that edge and stays at 1 until a stop request is accepted, which clears it.
- R4: In STOPPED, the first 0→1 change of `pin_rxd` produces a one-cycle `wake_irq` pulse. The pulse is high after the third rising clock edge that follows the pin change. No input can mask it.
- R5: `link_clk_en` returns to 1 exactly STARTUP_CYCLES clock cycles after `wake_irq` rises.
- R6: From stop entry until the bus is next declared idle, `rx_discard`=1 and `link_rxd` is held at 0, so the waking frame never reaches the link.
- R7: With `dig_lpbk`=1, `pin_txd`=0 and `link_rxd` equals `link_txd` in the same cycle. `pin_rxd` has no effect on `link_rxd`.
- R8: With `ana_lpbk`=1 (and `dig_lpbk`=0), `pin_txd` equals `link_txd`, and `link_rxd` follows `pin_rxd` two clock edges later.
- R9: When the last active loopback bit falls and the pin is quiet, `tx_hold` is high for exactly IDLE_CYCLES+1 cycles.
- R10: Any active sample on the synchronised receive line during an idle wait restarts the idle count. `tx_hold` then falls IDLE_CYCLES+3 cycles after `pin_rxd` returns to 0.
- R11: After a wake, `tx_hold` stays 1 while the waking frame is active and falls IDLE_CYCLES+3 cycles after `pin_rxd` returns to 0.
- R12: After reset, `link_clk_en`=1, and `tx_hold`, `wake_irq`, `rx_discard` and `stop_refused` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wcm_arm | input | 1 | Stop arm bit from the control register |
| stop_req | input | 1 | CPU stop command, one-cycle pulse |
| tx_active | input | 1 | Link reports a transmission in progress |
| dig_lpbk | input | 1 | Digital loopback select |
| ana_lpbk | input | 1 | Analog loopback select |
| link_txd | input | 1 | Transmit data from the link core |
| link_rxd | output | 1 | Receive data to the link core |
| pin_txd | output | 1 | Transmit pin to the transceiver |
| pin_rxd | input | 1 | Receive pin from the transceiver |
| link_clk_en | output | 1 | Clock enable for the link core |
| wake_irq | output | 1 | Non-maskable wake interrupt pulse |
| rx_discard | output | 1 | Current receive data must be dropped |
| tx_hold | output | 1 | Link must not start a transmission |
| stop_refused | output | 1 | Sticky flag: a stop was refused during a transmission |

## Verification
Each result has a fixed latency, counted from the edge that samples the stimulus:
- A stop decision takes one edge.
- The pin synchroniser adds two edges.
- The wake pulse adds a third edge.
- The clock enable returns STARTUP_CYCLES edges after the pulse.
- An idle wait ends IDLE_CYCLES+1 edges after the count restarts.

Inputs change on the falling edge, and every output is read on a later falling edge. Delays are measured by counting falling edges while the output holds its value, and each count is compared with the value derived above.

// File: rtl/bwl_pkg.sv
package bwl_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_STOPPED,
        ST_STARTUP,
        ST_WAKE_WAIT,
        ST_LB_WAIT
    } bwl_state_e;
endpackage

// File: rtl/bwl_sync.sv
module bwl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], din};
    end

    assign dout = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/bwl_idle_det.sv
module bwl_idle_det #(
    parameter int IDLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    input  logic restart,
    output logic bus_idle
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_CYCLES);

    logic [CW-1:0] quiet_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 quiet_cnt <= '0;
        else if (restart || rx)     quiet_cnt <= '0;
        else if (quiet_cnt != IDLE_MAX) quiet_cnt <= quiet_cnt + 1'b1;
    end

    assign bus_idle = (quiet_cnt == IDLE_MAX);

    AST_ACTIVE_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx || restart) |=> !bus_idle); // R10
endmodule

// File: rtl/bwl_fsm.sv
module bwl_fsm
    import bwl_pkg::*;
#(
    parameter int STARTUP_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wcm_arm,
    input  logic stop_req,
    input  logic tx_active,
    input  logic lb_any,
    input  logic rx_rise,
    input  logic bus_idle,
    output logic idle_restart,
    output logic wake_irq,
    output logic stop_refused,
    output logic clk_en,
    output logic tx_hold,
    output logic discard
);
    localparam int SW = $clog2(STARTUP_CYCLES + 1);
    localparam logic [SW-1:0] SU_LAST = SW'(STARTUP_CYCLES - 1);

    bwl_state_e state, state_nx;
    logic [SW-1:0] su_cnt;
    logic lb_prev;
    logic stop_ok, stop_bad;

    assign stop_ok  = stop_req && wcm_arm && !tx_active;
    assign stop_bad = stop_req && wcm_arm && tx_active;

    always_comb begin
        state_nx     = state;
        idle_restart = 1'b0;
        unique case (state)
            ST_RUN: begin
                if ((state == ST_RUN) && stop_ok) begin
                    state_nx = ST_STOPPED;
                end else if (lb_prev && !lb_any) begin
                    state_nx     = ST_LB_WAIT;
                    idle_restart = 1'b1;
                end
            end
            ST_STOPPED:   if (rx_rise) state_nx = ST_STARTUP;
            ST_STARTUP: begin
                if (su_cnt == SU_LAST) begin
                    state_nx     = ST_WAKE_WAIT;
                    idle_restart = 1'b1;
                end
            end
            ST_WAKE_WAIT: if (bus_idle) state_nx = ST_RUN;
            ST_LB_WAIT:   if (bus_idle) state_nx = ST_RUN;
            default:      state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            su_cnt       <= '0;
            lb_prev      <= 1'b0;
            wake_irq     <= 1'b0;
            stop_refused <= 1'b0;
        end else begin
            su_cnt   <= (state == ST_STARTUP) ? su_cnt + 1'b1 : '0;
            lb_prev  <= lb_any;
            wake_irq <= (state == ST_STOPPED) && rx_rise;
            if (state == ST_RUN && stop_ok)       stop_refused <= 1'b0;
            else if (state == ST_RUN && stop_bad) stop_refused <= 1'b1;
        end
    end

    always_comb begin
        clk_en  = 1'b1;
        tx_hold = 1'b0;
        discard = 1'b0;
        unique case (state)
            ST_RUN:       begin clk_en = 1'b1; tx_hold = 1'b0; discard = 1'b0; end
            ST_STOPPED:   begin clk_en = 1'b0; tx_hold = 1'b1; discard = 1'b1; end
            ST_STARTUP:   begin clk_en = 1'b0; tx_hold = 1'b1; discard = 1'b1; end
            ST_WAKE_WAIT: begin clk_en = 1'b1; tx_hold = 1'b1; discard = 1'b1; end
            ST_LB_WAIT:   begin clk_en = 1'b1; tx_hold = 1'b1; discard = 1'b0; end
            default:      begin clk_en = 1'b1; tx_hold = 1'b0; discard = 1'b0; end
        endcase
    end

    AST_REFUSED_STAYS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req && tx_active) |=> (state != ST_STOPPED)); // R3
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOPPED && !rx_rise) |=> (state == ST_STOPPED)); // R4
    AST_WAKE_IN_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> (state == ST_STARTUP)); // R5
    AST_WAIT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LB_WAIT || state == ST_WAKE_WAIT) && !bus_idle) |=> (state != ST_RUN)); // R9
endmodule

// File: rtl/bus_wake_lpbk.sv
module bus_wake_lpbk #(
    parameter int IDLE_CYCLES    = 16,
    parameter int STARTUP_CYCLES = 32,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wcm_arm,
    input  logic stop_req,
    input  logic tx_active,
    input  logic dig_lpbk,
    input  logic ana_lpbk,
    input  logic link_txd,
    output logic link_rxd,
    output logic pin_txd,
    input  logic pin_rxd,
    output logic link_clk_en,
    output logic wake_irq,
    output logic rx_discard,
    output logic tx_hold,
    output logic stop_refused
);
    logic rx_s, rx_rise, bus_idle, idle_restart, eff_rx;

    bwl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_rxd), .dout(rx_s), .rise(rx_rise)
    );

    bwl_idle_det #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk(clk), .rst_n(rst_n), .rx(rx_s), .restart(idle_restart), .bus_idle(bus_idle)
    );

    bwl_fsm #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wcm_arm(wcm_arm), .stop_req(stop_req),
        .tx_active(tx_active), .lb_any(dig_lpbk | ana_lpbk), .rx_rise(rx_rise),
        .bus_idle(bus_idle), .idle_restart(idle_restart), .wake_irq(wake_irq),
        .stop_refused(stop_refused), .clk_en(link_clk_en), .tx_hold(tx_hold),
        .discard(rx_discard)
    );

    // Digital loopback: internal return path, pin held passive.
    assign eff_rx   = dig_lpbk ? link_txd : rx_s;
    assign pin_txd  = dig_lpbk ? 1'b0 : link_txd;
    assign link_rxd = rx_discard ? 1'b0 : eff_rx;

    AST_CLK_OFF_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_clk_en) |-> $past(wcm_arm && stop_req && !tx_active)); // R1
    AST_DISCARD_QUIETS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_irq) |-> (rx_discard && !link_rxd)); // R6
endmodule

// File: tb/test_bus_wake_lpbk.sv
module test_bus_wake_lpbk;
    localparam int IDLE = 16;
    localparam int SU   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wcm_arm = 0, stop_req = 0, tx_active = 0, dig_lpbk = 0, ana_lpbk = 0;
    logic link_txd = 0, pin_rxd = 0;
    logic link_rxd, pin_txd, link_clk_en, wake_irq, rx_discard, tx_hold, stop_refused;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    bus_wake_lpbk #(.IDLE_CYCLES(IDLE), .STARTUP_CYCLES(SU)) i_bus_wake_lpbk (
        .clk(clk), .rst_n(rst_n), .wcm_arm(wcm_arm), .stop_req(stop_req),
        .tx_active(tx_active), .dig_lpbk(dig_lpbk), .ana_lpbk(ana_lpbk),
        .link_txd(link_txd), .link_rxd(link_rxd), .pin_txd(pin_txd), .pin_rxd(pin_rxd),
        .link_clk_en(link_clk_en), .wake_irq(wake_irq), .rx_discard(rx_discard),
        .tx_hold(tx_hold), .stop_refused(stop_refused)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R12 clk_en", link_clk_en, 1);
        check("R12 tx_hold", tx_hold, 0);
        check("R12 wake_irq", wake_irq, 0);
        check("R12 rx_discard", rx_discard, 0);
        check("R12 stop_refused", stop_refused, 0);
    endtask

    task automatic t_stop_ignored;
        wcm_arm = 1; tick(3);
        check("R2 arm only clk_en", link_clk_en, 1);
        wcm_arm = 0; stop_req = 1; tick(1); stop_req = 0; tick(2);
        check("R2 unarmed stop clk_en", link_clk_en, 1);
        check("R2 unarmed stop tx_hold", tx_hold, 0);
    endtask

    task automatic t_refused;
        wcm_arm = 1; tx_active = 1; stop_req = 1; tick(1); stop_req = 0;
        check("R3 refused clk_en", link_clk_en, 1);
        check("R3 refused flag", stop_refused, 1);
        tx_active = 0; tick(2);
        check("R3 flag sticky", stop_refused, 1);
        wcm_arm = 0;
    endtask

    task automatic t_digital;
        dig_lpbk = 1; link_txd = 1; pin_rxd = 0; #1;
        check("R7 pin_txd passive", pin_txd, 0);
        check("R7 rx follows tx high", link_rxd, 1);
        tick(1); link_txd = 0; pin_rxd = 1; tick(3);
        check("R7 pin_rxd ignored", link_rxd, 0);
        pin_rxd = 0; tick(3);
    endtask

    task automatic t_lb_exit;
        int n = 0;
        dig_lpbk = 0; tick(1);
        while (tx_hold && n < 1000) begin n++; tick(1); end
        check("R9 hold length after digital exit", n, IDLE + 1);
    endtask

    task automatic t_analog;
        int n = 0;
        ana_lpbk = 1; link_txd = 1; #1;
        check("R8 pin_txd follows", pin_txd, 1);
        tick(1); link_txd = 0; pin_rxd = 1; tick(1);
        check("R8 one edge not yet", link_rxd, 0);
        tick(1);
        check("R8 two edges delivered", link_rxd, 1);
        pin_rxd = 0; tick(3);
        ana_lpbk = 0; tick(5);
        check("R10 hold during wait", tx_hold, 1);
        pin_rxd = 1; tick(1); pin_rxd = 0;
        while (tx_hold && n < 1000) begin n++; tick(1); end
        check("R10 restart length", n, IDLE + 3);
    endtask

    task automatic t_stop_wake;
        int n = 0;
        wcm_arm = 1; stop_req = 1; tick(1); stop_req = 0;
        check("R1 clk_en off", link_clk_en, 0);
        check("R1 tx_hold", tx_hold, 1);
        check("R3 flag cleared", stop_refused, 0);
        tick(4);
        check("R4 no wake yet", wake_irq, 0);
        pin_rxd = 1; tick(2);
        check("R4 wake not early", wake_irq, 0);
        tick(1);
        check("R4 wake pulse", wake_irq, 1);
        check("R6 discard at wake", rx_discard, 1);
        while (!link_clk_en && n < 1000) begin n++; tick(1); end
        check("R5 startup delay", n, SU);
        check("R4 pulse one cycle", wake_irq, 0);
        tick(10);
        check("R6 rx held low", link_rxd, 0);
        check("R6 discard during frame", rx_discard, 1);
        check("R11 hold during frame", tx_hold, 1);
        pin_rxd = 0; n = 0;
        while (tx_hold && n < 1000) begin n++; tick(1); end
        check("R11 idle after wake", n, IDLE + 3);
        check("R6 discard ends", rx_discard, 0);
        wcm_arm = 0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        tick(3); rst_n = 1; tick(1);
        t_reset();
        t_stop_ignored();
        t_refused();
        t_digital();
        t_lb_exit();
        t_analog();
        t_stop_wake();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule